// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block supplies the column address for every beat of a synchronous DRAM read or write burst. When the command logic accepts a READ or WRITE, it pulses a start request together with the starting column and a burst-length code. The generator captures both values. From the next cycle it presents one column per clock on `col_o`, with `beat_vld_o` high for each beat. On the beat that closes the burst it raises `last_o` for exactly one cycle.

The fixed lengths (two, four and eight beats) step in sequential order inside the naturally aligned block that holds the starting column. The upper column bits stay fixed while the low bits count and wrap. Full-page mode steps through the whole 512-column row, wrapping from the top column back to zero, and runs until a terminate request arrives. A terminate request cuts any running burst short at the current beat. A start request on the closing beat chains the next burst with no idle cycle.

The control is a two-state machine. ST_IDLE (after reset) moves to ST_BURST on the transition START. ST_BURST stays in ST_BURST on STEP (a beat that is not the closing beat) and on CHAIN (the closing beat together with a start request). It returns to ST_IDLE on FINISH (the closing beat with no start request).

Top module: `sdram_col_burst_gen`

## Requirements
- R1: After reset `beat_vld_o` and `last_o` are low, and they stay low until a start request is taken.
- R2: A start request seen in ST_IDLE makes the first beat appear on the next cycle, with `col_o` equal to the `start_col_i` captured with the request.
- R3: The burst-length code sets the beat count: 0 gives one beat, 1 gives two, 2 gives four and 3 gives eight. Codes 4, 5 and 6 give one beat, and code 7 selects full page.
- R4: In a burst of two, four or eight beats, the low 1, 2 or 3 column bits count up by one per beat and wrap to zero inside the aligned block, while the upper column bits keep their starting value.
- R5: In full-page mode the column goes up by one per beat and wraps from 511 to 0. The burst continues until a terminate request.
- R6: `last_o` is high for one cycle, only on the closing beat of a burst, and never when `beat_vld_o` is low.
- R7: A terminate request during any beat makes that beat the closing beat: `last_o` is high in that same cycle, and with no start request `beat_vld_o` is low on the next cycle.
- R8: A terminate request while no burst runs has no effect: no beat appears, and a later burst runs its full length.
- R9: A start request on the closing beat (normal or terminated) begins the next burst on the following cycle, with no gap and with the newly captured column.
- R10: A start request during a beat that is not the closing beat is ignored, and the running burst continues unchanged.
- R11: The burst-length code is sampled only at start, so changing `burst_len_i` during a burst does not change that burst.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request from the accepted READ or WRITE |
| start_col_i | input | 9 | Starting column captured with the start request |
| burst_len_i | input | 3 | Burst-length code (see R3) |
| term_i | input | 1 | Burst terminate request |
| col_o | output | 9 | Column address of the current beat |
| beat_vld_o | output | 1 | High in each cycle that carries a beat |
| last_o | output | 1 | High on the closing beat of a burst |

## Verification
Two situations are hard to reach from the ports. The first is the full-page wrap from column 511 to 0. The second is a chained start landing on a closing beat that was itself produced by a terminate. The stimulus reaches the wrap by starting a full-page burst a few columns below the top of the row and terminating it after the wrap. It reaches the chained case by raising the terminate and a new start request in the same cycle of a running eight-beat burst. A scoreboard stamps every expected beat with its cycle number. Any gap, early beat or stray beat is therefore reported as well as any wrong column.

// File: rtl/col_burst_pkg.sv
package col_burst_pkg;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_BURST = 1'b1
    } burst_st_e;

    localparam logic [2:0] LEN_ONE   = 3'd0;
    localparam logic [2:0] LEN_TWO   = 3'd1;
    localparam logic [2:0] LEN_FOUR  = 3'd2;
    localparam logic [2:0] LEN_EIGHT = 3'd3;
    localparam logic [2:0] LEN_PAGE  = 3'd7;

endpackage

// File: rtl/cb_len_decode.sv
module cb_len_decode
    import col_burst_pkg::*;
#(
    parameter int COL_W = 9,
    parameter int CNT_W = 3
) (
    input  logic [2:0]       code_i,
    output logic [COL_W-1:0] wrap_mask_o,
    output logic [CNT_W-1:0] beats_m1_o,
    output logic             page_o
);
    always_comb begin
        wrap_mask_o = '0;
        beats_m1_o  = '0;
        page_o      = 1'b0;
        unique case (code_i)
            LEN_TWO: begin
                wrap_mask_o = COL_W'(1);
                beats_m1_o  = CNT_W'(1);
            end
            LEN_FOUR: begin
                wrap_mask_o = COL_W'(3);
                beats_m1_o  = CNT_W'(3);
            end
            LEN_EIGHT: begin
                wrap_mask_o = COL_W'(7);
                beats_m1_o  = CNT_W'(7);
            end
            LEN_PAGE: begin
                wrap_mask_o = '1;
                page_o      = 1'b1;
            end
            default: begin
                wrap_mask_o = '0;
                beats_m1_o  = '0;
            end
        endcase
    end
endmodule

// File: rtl/cb_col_step.sv
module cb_col_step #(
    parameter int COL_W = 9
) (
    input  logic [COL_W-1:0] col_i,
    input  logic [COL_W-1:0] wrap_mask_i,
    output logic [COL_W-1:0] col_nxt_o
);
    logic [COL_W-1:0] col_inc;

    assign col_inc = col_i + COL_W'(1);

    // bits inside the wrap window count, bits above it hold
    for (genvar b = 0; b < COL_W; b++) begin : g_bit
        assign col_nxt_o[b] = wrap_mask_i[b] ? col_inc[b] : col_i[b];
    end
endmodule

// File: rtl/sdram_col_burst_gen.sv
module sdram_col_burst_gen
    import col_burst_pkg::*;
#(
    parameter int COL_W  = 9,
    parameter int MAX_BL = 8,
    localparam int CNT_W = $clog2(MAX_BL)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [COL_W-1:0] start_col_i,
    input  logic [2:0]       burst_len_i,
    input  logic             term_i,
    output logic [COL_W-1:0] col_o,
    output logic             beat_vld_o,
    output logic             last_o
);
    burst_st_e        state_q, state_d;
    logic [COL_W-1:0] col_q, mask_q, dec_mask, col_nxt;
    logic [CNT_W-1:0] left_q, dec_left;
    logic             page_q, dec_page;
    logic             end_beat, load;

    cb_len_decode #(.COL_W(COL_W), .CNT_W(CNT_W)) u_dec (
        .code_i      (burst_len_i),
        .wrap_mask_o (dec_mask),
        .beats_m1_o  (dec_left),
        .page_o      (dec_page)
    );

    cb_col_step #(.COL_W(COL_W)) u_step (
        .col_i       (col_q),
        .wrap_mask_i (mask_q),
        .col_nxt_o   (col_nxt)
    );

    assign end_beat = (state_q == ST_BURST) &&
                      (term_i || (!page_q && (left_q == '0)));
    assign load     = start_i && ((state_q == ST_IDLE) || end_beat);

    // next state: START, STEP, CHAIN, FINISH
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start_i) state_d = ST_BURST;
            ST_BURST: if (end_beat && !start_i) state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            col_q  <= '0;
            mask_q <= '0;
            left_q <= '0;
            page_q <= 1'b0;
        end else if (load) begin
            col_q  <= start_col_i;
            mask_q <= dec_mask;
            left_q <= dec_left;
            page_q <= dec_page;
        end else if (state_q == ST_BURST) begin
            col_q <= col_nxt;
            if (!page_q) left_q <= left_q - CNT_W'(1);
        end
    end

    always_comb begin
        beat_vld_o = (state_q == ST_BURST);
        col_o      = col_q;
        last_o     = end_beat;
    end

    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !beat_vld_o && !start_i |=> !beat_vld_o);
    a_r2_first_col: assert property (@(posedge clk) disable iff (!rst_n)
        !beat_vld_o && start_i |=> beat_vld_o && col_o == $past(start_col_i));
    a_r5_page_step: assert property (@(posedge clk) disable iff (!rst_n)
        beat_vld_o && page_q && !last_o |=> col_o == $past(col_o) + COL_W'(1));
    a_r6_last_in_beat: assert property (@(posedge clk) disable iff (!rst_n)
        last_o |-> beat_vld_o);
    a_r7_term_closes: assert property (@(posedge clk) disable iff (!rst_n)
        beat_vld_o && term_i |-> last_o);
    a_r7_finish_idle: assert property (@(posedge clk) disable iff (!rst_n)
        last_o && !start_i |=> !beat_vld_o);
    a_r9_chain: assert property (@(posedge clk) disable iff (!rst_n)
        last_o && start_i |=> beat_vld_o && col_o == $past(start_col_i));
    a_r10_mid_continue: assert property (@(posedge clk) disable iff (!rst_n)
        beat_vld_o && !last_o |=> beat_vld_o);
endmodule

// File: tb/sdram_col_burst_gen_test.sv
module sdram_col_burst_gen_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic [8:0] start_col_i = '0;
    logic [2:0] burst_len_i = '0;
    logic       term_i = 1'b0;
    logic [8:0] col_o;
    logic       beat_vld_o, last_o;

    sdram_col_burst_gen uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_col_i(start_col_i),
        .burst_len_i(burst_len_i), .term_i(term_i),
        .col_o(col_o), .beat_vld_o(beat_vld_o), .last_o(last_o)
    );

    always #5 clk = ~clk;

    typedef struct {
        int         cyc;
        logic [8:0] col;
        bit         last;
        string      tag;
    } beat_t;

    beat_t q[$];
    beat_t mon_e;
    int    cyc = 0;
    int    n_chk = 0;
    int    n_fail = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(bit ok, string tag, string msg);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: %s", tag, msg);
        end
    endtask

    // expected beats of one burst; term_at < 0 means no terminate
    task automatic push(int first, logic [8:0] col, logic [2:0] code, int term_at, string tag);
        int n;
        logic [8:0] m;
        case (code)
            3'd1: begin n = 2; m = 9'd1; end
            3'd2: begin n = 4; m = 9'd3; end
            3'd3: begin n = 8; m = 9'd7; end
            3'd7: begin n = 100000; m = 9'h1FF; end
            default: begin n = 1; m = 9'd0; end
        endcase
        if (term_at >= 0 && term_at < n) n = term_at + 1;
        for (int k = 0; k < n; k++) begin
            beat_t b;
            b.cyc  = first + k;
            b.col  = (col & ~m) | ((col + 9'(k)) & m);
            b.last = (k == n - 1);
            b.tag  = tag;
            q.push_back(b);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    // raises start for one cycle; returns in the first beat cycle
    task automatic start(logic [8:0] col, logic [2:0] code, int term_at, string tag);
        start_i     = 1'b1;
        start_col_i = col;
        burst_len_i = code;
        push(cyc + 1, col, code, term_at, tag);
        tick();
        start_i = 1'b0;
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            if (last_o && !beat_vld_o)
                check(1'b0, "R6", "last_o=1 with beat_vld_o=0, expected last_o=0");
            if (q.size() > 0 && q[0].cyc < cyc) begin
                mon_e = q.pop_front();
                check(1'b0, mon_e.tag, $sformatf("missed beat col=%0d at cycle %0d",
                      mon_e.col, mon_e.cyc));
            end
            if (q.size() > 0 && q[0].cyc == cyc) begin
                mon_e = q.pop_front();
                check(beat_vld_o === 1'b1 && col_o === mon_e.col && last_o === mon_e.last,
                      mon_e.tag,
                      $sformatf("vld=%0b col=%0d last=%0b, expected vld=1 col=%0d last=%0b",
                                beat_vld_o, col_o, last_o, mon_e.col, mon_e.last));
            end else if (beat_vld_o) begin
                check(1'b0, "R8/R10", $sformatf("stray beat col=%0d, expected none", col_o));
            end
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        check(1'b0, "watchdog", "run did not finish, expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        idle(3);
        #4;
        check(beat_vld_o === 1'b0 && last_o === 1'b0, "R1",
              $sformatf("in reset vld=%0b last=%0b, expected 0 0", beat_vld_o, last_o));
        @(posedge clk); #1;
        rst_n = 1'b1;
        idle(3);
        check(beat_vld_o === 1'b0 && last_o === 1'b0, "R1",
              $sformatf("after reset vld=%0b last=%0b, expected 0 0", beat_vld_o, last_o));

        // R2 R3: single beat and the spare codes
        start(9'd5, 3'd0, -1, "R2");
        idle(3);
        start(9'd3, 3'd5, -1, "R3");
        idle(3);
        // R4: aligned wraps
        start(9'd7, 3'd1, -1, "R4");
        idle(3);
        start(9'd510, 3'd2, -1, "R4");
        idle(5);
        start(9'd13, 3'd3, -1, "R4");
        idle(9);
        // R5: full page across the top of the row
        start(9'd509, 3'd7, 5, "R5");
        idle(5);
        term_i = 1'b1; tick(); term_i = 1'b0;
        idle(3);
        // R7: terminate mid-burst and on the first beat
        start(9'd40, 3'd3, 2, "R7");
        idle(2);
        term_i = 1'b1; tick(); term_i = 1'b0;
        idle(3);
        start(9'd64, 3'd2, 0, "R7");
        term_i = 1'b1; tick(); term_i = 1'b0;
        idle(3);
        // R8: terminate while idle, then a full burst
        term_i = 1'b1; idle(3); term_i = 1'b0;
        start(9'd100, 3'd2, -1, "R8");
        idle(5);
        // R9: chain on a normal closing beat, then on a terminated one
        start(9'd10, 3'd2, -1, "R9");
        idle(3);
        start(9'd200, 3'd3, 3, "R9");
        idle(3);
        term_i = 1'b1;
        start(9'd300, 3'd1, -1, "R9");
        term_i = 1'b0;
        idle(4);
        // R10 R11: mid-burst start and length change are ignored
        start(9'd20, 3'd3, -1, "R10");
        tick();
        burst_len_i = 3'd0;
        tick();
        start_i = 1'b1; start_col_i = 9'd100; tick(); start_i = 1'b0;
        burst_len_i = 3'd7;
        idle(8);
        check(q.size() == 0, "R11", $sformatf("%0d beats pending, expected 0", q.size()));
        check(beat_vld_o === 1'b0, "R7",
              $sformatf("vld=%0b after all bursts, expected 0", beat_vld_o));
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule